// File: doc/BRIEF.md
# Row Refresh and Self-Refresh Sequencer

This block controls refresh for a DRAM array that sits behind a row cache. It watches the active-low strobes of the memory interface and issues array refresh requests that take their row from an internal counter. Three triggers start a refresh. The refresh pin held low at the falling edge of row-enable is one. The column strobe held low ahead of that edge is another. The third is a self-refresh mode, in which an internal timer paces the refreshes for as long as row-enable stays low. Throughout a counter refresh, cache reads stay enabled, so the refresh is hidden behind them.

The block also follows the power-up sequence. Row-enable must first stay high for a set time. After that the sequence needs a number of counter refreshes and reads to distinct rows. Only then does the block raise a ready flag. Cycles that the sequence forbids set sticky error flags. All strobes are sampled on the block clock, and an edge of row-enable is seen as a change between two samples.

Top module: `refresh_sequencer`

## Requirements
- R1: When a row-enable falling edge is sampled with `rfsh_n` low, `rfsh_req` is high for exactly one cycle. The pulse starts the cycle after the edge sample in which the fall is seen, and `rfsh_row` shows the counter row during it. `cal_n`, `sel_n`, `wr`, `we_n` and `row_addr` have no effect on such a cycle: they raise no error and do not change the row.
- R2: The refresh counter is `$clog2(REF_ROWS)` bits wide (10 by default) and is zero-extended onto `rfsh_row`, so the top row bit is always 0. It increments by one on the edge that ends each refresh pulse. It wraps from `REF_ROWS-1` to 0.
- R3: A falling edge with `rfsh_n` high is a counter refresh identical to R1 when `cal_n` was low at the previous sample and is still low at the fall, unless the pins form the self-refresh pattern of R4. `row_addr` is ignored.
- R4: After ready, a fall with `sel_n`, `wr`, `rfsh_n` and `we_n` high and `cal_n` low enters self-refresh. `self_rfsh` goes high the next cycle and stays high while `row_en_n` is low. It clears on the edge that first samples `row_en_n` high.
- R5: In self-refresh, `rfsh_req` pulses once every TICK = `INTERVAL_CYC/REF_ROWS` cycles (16 by default). The first pulse comes TICK cycles after the entry pulse would have appeared.
- R6: For `PRE_CYC` cycles after self-refresh exit, a row-enable fall is ignored: no refresh and no mode change. Such a fall sets `recov_err`, which stays set until reset.
- R7: `cache_rd_ok` is high at all times except during self-refresh. This includes the cycles of a counter refresh.
- R8: `ready` rises only when three counts are met. Row-enable must first have been high for `PWRUP_CYC` (8) consecutive cycles. After that, at least `INIT_RFSH` (8) counter refreshes and `INIT_RDS` (2) reads must occur, a read being a fall with `sel_n` low, `wr` low and `rfsh_n`/`cal_n` high. A read only counts if its row differs from the previous read's row. Once high, `ready` stays high.
- R9: `init_err` is set by three cycles: any row-enable fall before the power-up time has elapsed (that fall is ignored), a write before ready, and a self-refresh entry before ready (that entry is ignored). A write is a fall with `sel_n` low and `wr` high. `init_err` stays set until reset.
- R10: During and right after reset, `rfsh_req`, `rfsh_row`, `self_rfsh`, `ready`, `init_err` and `recov_err` are 0 and `cache_rd_ok` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| row_en_n | input | 1 | Row-enable strobe, active low |
| rfsh_n | input | 1 | Refresh request pin, active low |
| cal_n | input | 1 | Column latch strobe, active low |
| sel_n | input | 1 | Chip select, active low |
| wr | input | 1 | High for write, low for read |
| we_n | input | 1 | Write enable, active low |
| row_addr | input | ROW_W | Row address presented at the fall |
| rfsh_req | output | 1 | One-cycle array refresh request |
| rfsh_row | output | ROW_W | Row to refresh (counter value) |
| self_rfsh | output | 1 | Self-refresh mode active |
| cache_rd_ok | output | 1 | Cache reads permitted |
| ready | output | 1 | Power-up sequence complete |
| init_err | output | 1 | Sticky: forbidden cycle during power-up |
| recov_err | output | 1 | Sticky: fall inside post-self-refresh recovery |

## Verification
The bench puts noisy write and address pins on a pin refresh before ready. A design that decoded those pins would flag an error or take the row from the address bus. It repeats a read of the same row, so a design that counted every read would raise ready too early. It also measures where the first self-refresh pulse lands, since an off-by-one in the timer moves that pulse. A fall inside the recovery window must be rejected, and the counter must wrap from 1023 to 0 rather than run into the eleventh row bit.

// File: rtl/refresh_sequencer.sv
module refresh_sequencer #(
  parameter int ROW_W        = 11,
  parameter int REF_ROWS     = 1024,
  parameter int INTERVAL_CYC = 16384,
  parameter int PRE_CYC      = 6,
  parameter int PWRUP_CYC    = 8,
  parameter int INIT_RFSH    = 8,
  parameter int INIT_RDS     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             row_en_n,
  input  logic             rfsh_n,
  input  logic             cal_n,
  input  logic             sel_n,
  input  logic             wr,
  input  logic             we_n,
  input  logic [ROW_W-1:0] row_addr,
  output logic             rfsh_req,
  output logic [ROW_W-1:0] rfsh_row,
  output logic             self_rfsh,
  output logic             cache_rd_ok,
  output logic             ready,
  output logic             init_err,
  output logic             recov_err
);
  localparam int CNT_W = $clog2(REF_ROWS);
  localparam int TICK  = INTERVAL_CYC / REF_ROWS;
  localparam int TMR_W = $clog2(TICK + 1);
  localparam int PRE_W = $clog2(PRE_CYC + 1);
  localparam int PU_W  = $clog2(PWRUP_CYC + 1);
  localparam int RF_W  = $clog2(INIT_RFSH + 1);
  localparam int RD_W  = $clog2(INIT_RDS + 1);
  localparam logic [TMR_W-1:0] TICK_LAST = TMR_W'(TICK - 1);
  localparam logic [PRE_W-1:0] PRE_LD    = PRE_W'(PRE_CYC);
  localparam logic [PU_W-1:0]  PU_LAST   = PU_W'(PWRUP_CYC - 1);
  localparam logic [RF_W-1:0]  RF_DONE   = RF_W'(INIT_RFSH);
  localparam logic [RD_W-1:0]  RD_DONE   = RD_W'(INIT_RDS);

  logic             re_q, cal_q, self_mode, pwr_ok, rd_any;
  logic [CNT_W-1:0] cnt;
  logic [TMR_W-1:0] tmr;
  logic [PRE_W-1:0] guard;
  logic [PU_W-1:0]  hi_cnt;
  logic [RF_W-1:0]  rf_cnt;
  logic [RD_W-1:0]  rd_cnt;
  logic [ROW_W-1:0] last_rd;

  wire fall    = re_q & ~row_en_n;
  wire in_rec  = guard != '0;
  wire go      = fall & pwr_ok & ~in_rec & ~self_mode;
  wire is_pin  = ~rfsh_n;
  wire is_self = sel_n & wr & rfsh_n & we_n & ~cal_n;
  wire is_cbr  = ~cal_n & ~cal_q & ~is_self;
  wire is_rd   = ~sel_n & ~wr & cal_n;
  wire is_wr   = ~sel_n & wr;
  wire plain   = go & ~is_pin & ~is_self & ~is_cbr;
  wire do_pin  = go & (is_pin | is_cbr);
  wire do_self = go & ~is_pin & is_self & ready;
  wire do_rd   = plain & is_rd;
  wire tick    = self_mode & ~row_en_n & (tmr == TICK_LAST);
  wire exit_sr = self_mode & row_en_n;
  wire bad     = (fall & ~pwr_ok) | (go & ~is_pin & ~ready & is_self) | (plain & is_wr & ~ready);
  wire new_row = ~rd_any | (row_addr != last_rd);

  assign ready       = pwr_ok & (rf_cnt == RF_DONE) & (rd_cnt == RD_DONE);
  assign rfsh_row    = {{(ROW_W-CNT_W){1'b0}}, cnt};
  assign self_rfsh   = self_mode;
  assign cache_rd_ok = ~self_mode;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      re_q <= 1'b1;  cal_q <= 1'b1;  rfsh_req <= 1'b0;  cnt <= '0;
      self_mode <= 1'b0;  tmr <= '0;  guard <= '0;
      pwr_ok <= 1'b0;  hi_cnt <= '0;  rf_cnt <= '0;  rd_cnt <= '0;
      rd_any <= 1'b0;  last_rd <= '0;  init_err <= 1'b0;  recov_err <= 1'b0;
    end else begin
      re_q     <= row_en_n;
      cal_q    <= cal_n;
      rfsh_req <= do_pin | tick;
      if (rfsh_req) cnt <= cnt + 1'b1;

      if (do_self)      self_mode <= 1'b1;
      else if (exit_sr) self_mode <= 1'b0;

      if (exit_sr)     guard <= PRE_LD;
      else if (in_rec) guard <= guard - 1'b1;

      if (do_self || !self_mode) tmr <= '0;
      else if (!row_en_n)        tmr <= tick ? '0 : tmr + 1'b1;

      if (!pwr_ok) begin
        if (!row_en_n)             hi_cnt <= '0;
        else if (hi_cnt == PU_LAST) pwr_ok <= 1'b1;
        else                        hi_cnt <= hi_cnt + 1'b1;
      end

      if (do_pin && rf_cnt != RF_DONE) rf_cnt <= rf_cnt + 1'b1;
      if (do_rd) begin
        rd_any  <= 1'b1;
        last_rd <= row_addr;
        if (new_row && rd_cnt != RD_DONE) rd_cnt <= rd_cnt + 1'b1;
      end

      init_err  <= init_err | bad;
      recov_err <= recov_err | (fall & pwr_ok & in_rec & ~self_mode);
    end
  end
endmodule

// File: rtl/refresh_sequencer_chk.sv
module refresh_sequencer_chk #(
  parameter int ROW_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             row_en_n,
  input logic             rfsh_n,
  input logic             cal_n,
  input logic             sel_n,
  input logic             wr,
  input logic             we_n,
  input logic             rfsh_req,
  input logic [ROW_W-1:0] rfsh_row,
  input logic             self_rfsh,
  input logic             ready,
  input logic             init_err,
  input logic             recov_err
);
  a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rfsh_req |=> !rfsh_req);

  a_r2_row_step: assert property (@(posedge clk) disable iff (!rst_n)
    rfsh_req |=> (rfsh_row == $past(rfsh_row) + 1'b1) || (rfsh_row == '0));

  a_r4_self_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(self_rfsh) |-> $past(!row_en_n && sel_n && wr && rfsh_n && we_n && !cal_n && ready));

  a_r6_recov_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    recov_err |=> recov_err);

  a_r8_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);

  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    init_err |=> init_err);
endmodule

bind refresh_sequencer refresh_sequencer_chk #(.ROW_W(ROW_W)) u_chk (.*);

// File: tb/refresh_sequencer_bench.sv
module refresh_sequencer_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic row_en_n = 1'b1, rfsh_n = 1'b1, cal_n = 1'b1, sel_n = 1'b0, wr = 1'b0, we_n = 1'b1;
  logic [10:0] row_addr = '0;
  logic rfsh_req, self_rfsh, cache_rd_ok, ready, init_err, recov_err;
  logic [10:0] rfsh_row;

  int checks = 0, fails = 0, mc = 0;
  logic got_req, got_ok;
  logic [10:0] got_row;

  always #2 clk = ~clk;

  refresh_sequencer u_refresh_sequencer (
    .clk(clk), .rst_n(rst_n), .row_en_n(row_en_n), .rfsh_n(rfsh_n), .cal_n(cal_n),
    .sel_n(sel_n), .wr(wr), .we_n(we_n), .row_addr(row_addr),
    .rfsh_req(rfsh_req), .rfsh_row(rfsh_row), .self_rfsh(self_rfsh),
    .cache_rd_ok(cache_rd_ok), .ready(ready), .init_err(init_err), .recov_err(recov_err));

  // {cbr, sel_n, wr, we_n, row_addr}
  localparam logic [14:0] VEC [0:6] = '{
    {1'b0, 1'b1, 1'b1, 1'b1, 11'h7FF},
    {1'b1, 1'b0, 1'b0, 1'b1, 11'h123},
    {1'b0, 1'b0, 1'b0, 1'b0, 11'h055},
    {1'b1, 1'b1, 1'b0, 1'b1, 11'h400},
    {1'b1, 1'b0, 1'b1, 1'b0, 11'h3AA},
    {1'b0, 1'b1, 1'b0, 1'b0, 11'h001},
    {1'b1, 1'b0, 1'b1, 1'b1, 11'h2C3}
  };

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic pins_idle();
    rfsh_n = 1'b1; cal_n = 1'b1; sel_n = 1'b0; wr = 1'b0; we_n = 1'b1;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; row_en_n = 1'b1; pins_idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic refresh_op(bit cbr, bit s, bit w, bit e, logic [10:0] a);
    @(negedge clk);
    sel_n = s; wr = w; we_n = e; row_addr = a;
    if (cbr) begin cal_n = 1'b0; rfsh_n = 1'b1; end
    else begin rfsh_n = 1'b0; cal_n = 1'b1; end
    @(negedge clk); row_en_n = 1'b0;
    @(negedge clk);
    got_req = rfsh_req; got_row = rfsh_row; got_ok = cache_rd_ok;
    row_en_n = 1'b1; pins_idle();
    @(negedge clk);
  endtask

  task automatic array_op(bit w, logic [10:0] a);
    @(negedge clk);
    pins_idle(); wr = w; we_n = ~w; row_addr = a;
    @(negedge clk); row_en_n = 1'b0;
    @(negedge clk); got_req = rfsh_req; row_en_n = 1'b1; pins_idle();
    @(negedge clk);
  endtask

  task automatic self_entry();
    @(negedge clk);
    sel_n = 1'b1; wr = 1'b1; rfsh_n = 1'b1; we_n = 1'b1; cal_n = 1'b0;
    @(negedge clk); row_en_n = 1'b0;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    // R10 reset state
    repeat (3) @(negedge clk);
    check("R10 rfsh_req", rfsh_req, 0);
    check("R10 rfsh_row", rfsh_row, 0);
    check("R10 self_rfsh", self_rfsh, 0);
    check("R10 ready", ready, 0);
    check("R10 errors", {init_err, recov_err}, 0);
    check("R10 cache_rd_ok", cache_rd_ok, 1);
    rst_n = 1'b1;

    // R9 fall during power-up idle is ignored and flagged
    @(negedge clk); rfsh_n = 1'b0; row_en_n = 1'b0;
    @(negedge clk);
    check("R9 early fall no refresh", rfsh_req, 0);
    check("R9 early fall init_err", init_err, 1);
    do_reset();
    repeat (12) @(negedge clk);

    // R1 pin refresh ignores write/address pins before ready
    refresh_op(1'b0, 1'b0, 1'b1, 1'b0, 11'h5A5);
    check("R1 pulse", got_req, 1);
    check("R1 row from counter", got_row, mc);
    check("R1 no error from ignored pins", init_err, 0);
    check("R7 cache read during refresh", got_ok, 1);
    check("R2 counter advanced", rfsh_row, mc + 1);
    check("R1 pulse single", rfsh_req, 0);
    mc++;

    for (int i = 0; i < 7; i++) begin
      refresh_op(VEC[i][14], VEC[i][13], VEC[i][12], VEC[i][11], VEC[i][10:0]);
      check(VEC[i][14] ? "R3 cbr pulse" : "R1 pin pulse", got_req, 1);
      check(VEC[i][14] ? "R3 cbr row" : "R1 pin row", got_row, mc);
      mc++;
      check("R2 step", rfsh_row, mc);
    end
    check("R9 no error on refreshes", init_err, 0);
    check("R8 not ready without reads", ready, 0);

    // R8 reads to distinct rows
    array_op(1'b0, 11'h005);
    array_op(1'b0, 11'h005);
    check("R8 repeated row not counted", ready, 0);
    array_op(1'b0, 11'h009);
    check("R8 ready after distinct reads", ready, 1);
    check("R8 read no refresh", got_req, 0);

    // R4 / R5 self-refresh
    self_entry();
    check("R4 self entry", self_rfsh, 1);
    check("R7 cache blocked in self", cache_rd_ok, 0);
    begin
      int pulses = 0, first = -1;
      for (int i = 0; i < 68; i++) begin
        @(negedge clk);
        if (rfsh_req) begin
          if (first < 0) first = i;
          pulses++;
        end
      end
      check("R5 pulse count", pulses, 4);
      check("R5 first pulse spacing", first, 15);
    end
    mc += 4;
    check("R2 rows advanced in self", rfsh_row, mc);
    row_en_n = 1'b1; pins_idle();
    @(negedge clk);
    check("R4 self exit", self_rfsh, 0);
    check("R7 cache restored", cache_rd_ok, 1);

    // R6 fall inside recovery window
    @(negedge clk); rfsh_n = 1'b0; row_en_n = 1'b0;
    @(negedge clk);
    check("R6 fall ignored", rfsh_req, 0);
    check("R6 recov_err", recov_err, 1);
    row_en_n = 1'b1; pins_idle();
    repeat (10) @(negedge clk);
    check("R6 counter untouched", rfsh_row, mc);
    refresh_op(1'b0, 1'b0, 1'b0, 1'b1, 11'h0);
    check("R6 refresh after window", got_req, 1);
    mc++;

    // R2 wrap
    while (mc < 1023) begin
      refresh_op(1'b0, 1'b0, 1'b0, 1'b1, 11'h0);
      mc++;
    end
    check("R2 top of range", rfsh_row, 1023);
    refresh_op(1'b1, 1'b0, 1'b0, 1'b1, 11'h7FF);
    check("R2 last row", got_row, 1023);
    check("R2 wrap to zero", rfsh_row, 0);

    // R9 write and self-refresh before ready
    do_reset();
    repeat (12) @(negedge clk);
    array_op(1'b1, 11'h010);
    check("R9 write before ready", init_err, 1);
    self_entry();
    check("R9 self entry ignored", self_rfsh, 0);
    row_en_n = 1'b1; pins_idle();
    @(negedge clk);

    summary();
    $finish;
  end
endmodule